// File: doc/BRIEF.md
# Locked Test-and-Set Bus Sequencer

This block performs an indivisible test-and-set on one byte of shared memory for a processor-side master. When the core asks for it, the block runs a single locked bus transfer. The transfer first fetches the byte at the given address. It then stores the same byte back with its most significant bit forced high. From the fetched value it reports two flags: a negative flag and a zero flag.

The lock output is high across the whole read-modify-write. A request to release the bus, such as a halt or a bus request from another master, is not granted while that lock is high. A semaphore owner can therefore never be interrupted between the test and the set. With no wait states the locked transfer spans exactly five clock cycles. That count is odd, so a system arbiter that counts in pairs of cycles must take note of it.

Top module: `tas_seq`

## Requirements
- R1: In the first locked cycle after a request is accepted, the bus drives the captured address with the address strobe high, the data strobe low and write-enable low (0 = read). The data strobe rises in the next cycle to read the byte.
- R2: The write phase sets write-enable high (1 = write) and drives the byte that was read with bit 7 (bit DATA_W-1) forced to one. The other bits are unchanged. Write data is driven in both the write address cycle and the write data cycle.
- R3: The negative flag equals bit 7 of the byte as read, before it is modified.
- R4: The zero flag is 1 exactly when the byte read was 0x00.
- R5: The lock output is high from the first read cycle until the cycle in which the write is acknowledged, and it falls in the next cycle. With acknowledges in the first data cycle of each phase, the lock is high for exactly 5 cycles. Each wait cycle adds one.
- R6: Each data phase holds its data strobe until the acknowledge is sampled high. While it waits, the address, write-enable and write data stay unchanged. Read data is taken only in the acknowledged cycle.
- R7: The done output pulses high for one cycle, starting in the cycle after the write acknowledge. The flags take their new values in that same cycle and keep them until the next sequence completes.
- R8: The release grant is high only while the block is idle and the release request is high. It is never high while the lock is high. While the release request is high in idle, a core request does not start a sequence.
- R9: A core request made while a sequence is in progress is ignored. No further sequence follows the current one.
- R10: During reset and after it, lock, both strobes, write-enable, done and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Core request to start a test-and-set (sampled while idle) |
| addr_i | input | ADDR_W | Byte address, captured when the request is accepted |
| rel_req_i | input | 1 | Request from another master to release the bus |
| done_o | output | 1 | One-cycle completion pulse |
| neg_o | output | 1 | Negative flag of the last completed operation |
| zero_o | output | 1 | Zero flag of the last completed operation |
| rel_grant_o | output | 1 | Bus release grant |
| bus_addr_o | output | ADDR_W | Memory bus address (0 when not locked) |
| bus_as_o | output | 1 | Address strobe |
| bus_ds_o | output | 1 | Data strobe |
| bus_we_o | output | 1 | Write-enable, 1 = write, 0 = read |
| bus_lock_o | output | 1 | Indivisible transfer in progress |
| bus_wdata_o | output | DATA_W | Write data (0 outside the write phase) |
| bus_rdata_i | input | DATA_W | Read data from memory |
| bus_ack_i | input | 1 | Memory acknowledge for the current data phase |

## Verification
The bench builds the block with its defaults, ADDR_W = 16 and DATA_W = 8, so the forced bit is bit 7. The whole byte space for the flags is reachable with a handful of chosen values: zero, only the top bit set, all ones, and values just below the top bit. Wait counts from zero to several cycles in either phase make the cycle count of the lock observable, along with address stability during stalls. Garbage read data on cycles without an acknowledge shows that only the acknowledged byte is used. A release request held through a sequence, and core requests made mid-sequence or during a grant, exercise the arbitration corner cases.

// File: rtl/tas_pkg.sv
package tas_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RADR = 3'd1,
    S_RDAT = 3'd2,
    S_MOD  = 3'd3,
    S_WADR = 3'd4,
    S_WDAT = 3'd5
  } tas_state_e;

  localparam int unsigned NOMINAL_LOCK_CYCLES = 5;

endpackage

// File: rtl/tas_fsm.sv
module tas_fsm
  import tas_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       rel_req_i,
  input  logic       ack_i,
  output logic       start_o,
  output logic       rd_done_o,
  output logic       wr_done_o,
  output logic       lock_o,
  output logic       as_o,
  output logic       ds_o,
  output logic       we_o,
  output logic       grant_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAST_BEFORE_WR =
    CNT_W'(NOMINAL_LOCK_CYCLES - 1);

  tas_state_e state_q, state_d;

  // Named events used by the datapath and the assertions
  logic idle_w;
  logic wait_w;
  assign idle_w    = (state_q == S_IDLE);
  assign start_o   = idle_w && req_i && !rel_req_i;
  assign rd_done_o = (state_q == S_RDAT) && ack_i;
  assign wr_done_o = (state_q == S_WDAT) && ack_i;
  assign wait_w    = ds_o && !ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_o)   state_d = S_RADR;
      S_RADR:                state_d = S_RDAT;
      S_RDAT: if (rd_done_o) state_d = S_MOD;
      S_MOD:                 state_d = S_WADR;
      S_WADR:                state_d = S_WDAT;
      S_WDAT: if (wr_done_o) state_d = S_IDLE;
      default:               state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign lock_o  = !idle_w;
  assign as_o    = lock_o;
  assign ds_o    = (state_q == S_RDAT) || (state_q == S_WDAT);
  assign we_o    = (state_q == S_WADR) || (state_q == S_WDAT);
  assign grant_o = idle_w && rel_req_i;

  // Locked cycles not spent waiting; drives the odd-length check only
  logic [CNT_W-1:0] act_cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n || idle_w)              act_cnt_q <= '0;
    else if (!wait_w && act_cnt_q != CNT_MAX) act_cnt_q <= act_cnt_q + 1'b1;
  end

  // R5: lock never drops before the write acknowledge
  a_r5_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !wr_done_o) |=> lock_o);

  // R5: lock falls right after the write acknowledge
  a_r5_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_o |=> !lock_o);

  // R5: five active cycles per sequence, the write ack being the last
  a_r5_five_active: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_o |-> (act_cnt_q == LAST_BEFORE_WR));

  // R9: a busy sequence is never restarted
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_w) |=> (state_q != S_RADR));

endmodule

// File: rtl/tas_datapath.sv
module tas_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_done_i,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              done_o
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] f_set_top(input logic [DATA_W-1:0] v);
    return v | TOP_BIT;
  endfunction

  function automatic logic f_neg(input logic [DATA_W-1:0] v);
    return v[MSB];
  endfunction

  function automatic logic f_zero(input logic [DATA_W-1:0] v);
    return (v == '0);
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rbyte_q;
  logic              neg_q, zero_q, done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rbyte_q <= '0;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= wr_done_i;
      if (start_i)   addr_q  <= addr_i;
      if (rd_done_i) rbyte_q <= rdata_i;
      if (wr_done_i) begin
        neg_q  <= f_neg(rbyte_q);
        zero_q <= f_zero(rbyte_q);
      end
    end
  end

  assign addr_q_o = addr_q;
  assign wdata_o  = f_set_top(rbyte_q);
  assign neg_o    = neg_q;
  assign zero_o   = zero_q;
  assign done_o   = done_q;

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: flags only move together with a completion
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done_i |=> ($stable(neg_o) && $stable(zero_o)));

endmodule

// File: rtl/tas_seq.sv
module tas_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rel_req_i,
  output logic              done_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              rel_grant_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_as_o,
  output logic              bus_ds_o,
  output logic              bus_we_o,
  output logic              bus_lock_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i
);

  logic              start_w, rd_done_w, wr_done_w;
  logic              lock_w, as_w, ds_w, we_w;
  logic [ADDR_W-1:0] addr_q_w;
  logic [DATA_W-1:0] wdata_w;

  tas_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .rel_req_i (rel_req_i),
    .ack_i     (bus_ack_i),
    .start_o   (start_w),
    .rd_done_o (rd_done_w),
    .wr_done_o (wr_done_w),
    .lock_o    (lock_w),
    .as_o      (as_w),
    .ds_o      (ds_w),
    .we_o      (we_w),
    .grant_o   (rel_grant_o)
  );

  tas_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .rd_done_i (rd_done_w),
    .wr_done_i (wr_done_w),
    .addr_i    (addr_i),
    .rdata_i   (bus_rdata_i),
    .addr_q_o  (addr_q_w),
    .wdata_o   (wdata_w),
    .neg_o     (neg_o),
    .zero_o    (zero_o),
    .done_o    (done_o)
  );

  assign bus_lock_o  = lock_w;
  assign bus_as_o    = as_w;
  assign bus_ds_o    = ds_w;
  assign bus_we_o    = we_w;
  assign bus_addr_o  = lock_w ? addr_q_w : '0;
  assign bus_wdata_o = we_w ? wdata_w : '0;

  // R1: a locked transfer opens with an address-only read cycle
  a_r1_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock_o) |-> (bus_as_o && !bus_ds_o && !bus_we_o));

  // R2: every write cycle carries the top bit set
  a_r2_top_set: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_o |-> bus_wdata_o[DATA_W-1]);

  // R6: a stalled data phase keeps the bus frozen
  a_r6_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ds_o && !bus_ack_i) |=>
      (bus_ds_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

  // R8: the bus is never handed over inside the locked transfer
  a_r8_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_grant_o && bus_lock_o));

  // R10: the address strobe never shows without the lock
  a_r10_strobe_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as_o || bus_ds_o || bus_we_o) |-> bus_lock_o);

endmodule

// File: tb/tas_seq_bench.sv
module tas_seq_bench;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int NV = 8;

  localparam logic [7:0] V_RD [NV] = '{8'h00, 8'h80, 8'h7F, 8'hFF,
                                       8'h01, 8'hC3, 8'h40, 8'h00};
  localparam int V_RW [NV] = '{0, 0, 1, 3, 0, 2, 5, 1};
  localparam int V_WW [NV] = '{0, 1, 0, 2, 4, 0, 1, 3};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rel = 1'b0;
  logic          done, neg, zero, grant;
  logic [AW-1:0] baddr;
  logic          bas, bds, bwe, block;
  logic [DW-1:0] bwdata;
  logic [DW-1:0] brdata = '0;
  logic          back = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tas_seq u_tas_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .rel_req_i(rel),
    .done_o(done), .neg_o(neg), .zero_o(zero), .rel_grant_o(grant),
    .bus_addr_o(baddr), .bus_as_o(bas), .bus_ds_o(bds), .bus_we_o(bwe),
    .bus_lock_o(block), .bus_wdata_o(bwdata), .bus_rdata_i(brdata),
    .bus_ack_i(back)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_tas(input logic [AW-1:0] a, input logic [7:0] rd,
                         input int rw, input int ww,
                         input bit hold_rel, input bit poke_req);
    int lc, rwc, wwc, it;
    logic [7:0] exp_w;
    exp_w = {1'b1, rd[6:0]};
    @(negedge clk); req = 1'b1; addr = a;
    @(negedge clk); req = 1'b0; addr = ~a;
    if (hold_rel) rel = 1'b1;
    chk(block && bas && !bds && !bwe, "R1 open cycle", {bds, bwe}, 32'h0);
    chk(baddr == a, "R1 address", baddr, a);
    lc = 0; rwc = 0; wwc = 0; it = 0;
    while (block && it < 100) begin
      lc++; it++;
      if (hold_rel) chk(!grant, "R8 grant while locked", grant, 0);
      if (poke_req) req = (it == 3);
      if (bds && !bwe) begin
        chk(baddr == a, "R6 read addr", baddr, a);
        if (rwc < rw) begin back = 1'b0; brdata = ~rd; rwc++; end
        else begin back = 1'b1; brdata = rd; end
      end else if (bds && bwe) begin
        chk(bwdata == exp_w, "R2 write data", bwdata, exp_w);
        chk(baddr == a, "R6 write addr", baddr, a);
        if (wwc < ww) begin back = 1'b0; wwc++; end
        else back = 1'b1;
        brdata = 8'h5A;
      end else begin
        back = 1'b0; brdata = 8'hA5;
        if (bwe) chk(bwdata == exp_w, "R2 write addr cycle data", bwdata, exp_w);
      end
      @(negedge clk);
    end
    back = 1'b0; req = 1'b0;
    chk(lc == 5 + rw + ww, "R5 lock length", lc, 5 + rw + ww);
    chk(done, "R7 done pulse", done, 1);
    chk(neg == rd[7], "R3 negative flag", neg, rd[7]);
    chk(zero == (rd == 8'h00), "R4 zero flag", zero, rd == 8'h00);
    if (hold_rel) chk(grant, "R8 grant after unlock", grant, 1);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    chk(neg == rd[7] && zero == (rd == 8'h00), "R7 flags hold", {neg, zero},
        {rd[7], rd == 8'h00});
    rel = 1'b0;
    if (poke_req) begin
      for (int k = 0; k < 3; k++) begin
        chk(!block, "R9 no second sequence", block, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!block && !bas && !bds && !bwe && !done && !neg && !zero,
        "R10 in reset", {block, bas, bds, bwe, done, neg, zero}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!block && !done && !neg && !zero && baddr == '0, "R10 after reset",
        {block, done, neg, zero}, 0);

    for (int i = 0; i < NV; i++)
      run_tas(AW'(16'h1000 + i * 37), V_RD[i], V_RW[i], V_WW[i], 1'b0, 1'b0);

    // release request held through a whole sequence
    run_tas(16'hBEEF, 8'h81, 2, 1, 1'b1, 1'b0);
    // core request during a busy sequence
    run_tas(16'h0042, 8'h00, 0, 0, 1'b0, 1'b1);

    // release request in idle wins over a core request
    @(negedge clk); rel = 1'b1; req = 1'b1; addr = 16'h7777;
    @(negedge clk);
    chk(grant && !block, "R8 idle grant blocks start", {grant, block}, 2'b10);
    req = 1'b0;
    @(negedge clk);
    chk(!block, "R8 no start under grant", block, 0);
    chk(!neg && zero, "R7 flags kept across grant", {neg, zero}, 2'b01);
    rel = 1'b0;
    @(negedge clk);
    chk(!grant, "R8 grant released", grant, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule